// File: doc/BRIEF.md
# Mask-Driven Byte Bit-Field Unit

This execution unit carries out two byte operations whose field is given by an 8-bit mask rather than by an offset and a width. The field position is the index of the lowest set bit of the mask. An 8-input priority encoder finds that index, and the unit then uses it as the shift amount.

A field load takes a memory byte and a mask. It keeps only the bits under the mask and shifts them down so that the field starts at bit 0. The result replaces the low byte of a 32-bit destination register value, and the upper 24 bits of that value pass through unchanged.

A field store takes the low byte of a source register value and shifts it up to the field position. It keeps the shifted bits that fall under the mask and fills every other bit from the old destination byte. The merged byte is returned for write-back.

A start strobe launches one operation. The result is registered, and `valid_o` pulses in the next cycle.

Top module: `bfu_top`

## Requirements
- R1: While reset is held and after its release, `valid_o` is 0 and `result_o` is 0 until the first start.
- R2: `valid_o` is 1 in exactly the cycle after each cycle in which `start_i` is 1, and 0 otherwise.
- R3: With `op_i`=0 (load), `result_o[7:0]` becomes (`mem_byte_i` AND `mask_i`) shifted right by the index of the lowest set bit of `mask_i`. For example, 0xA5 with mask 0x3C gives 0x09, and 0xA5 with mask 0x80 gives 0x01.
- R4: For a load, `result_o[31:8]` equals `reg_val_i[31:8]`. For example, 0xA5A5A5A5 with mask 0xF0 and byte 0xA5 gives 0xA5A5A50A.
- R5: With `op_i`=1 (store), `result_o[7:0]` becomes ((`reg_val_i[7:0]` shifted left by the lowest-set-bit index) AND `mask_i`) OR (`mem_byte_i` AND NOT `mask_i`), and `result_o[31:8]` is 0. For example, source 0xA5 with mask 0x3C into 0xC3 gives 0xD7.
- R6: When `mask_i` is 0, the shift index is 0. A load then gives a low byte of 0, and a store returns `mem_byte_i` unchanged.
- R7: A mask with gaps uses the same formulas, and the field bits are not compacted. For example, a load of 0xA5 with mask 0x81 gives 0x81, and a store of source 0x03 with mask 0x81 into 0x00 gives 0x01.
- R8: In a cycle without `start_i`, `result_o` keeps its value, whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launches one operation |
| op_i | input | 1 | 0 = field load, 1 = field store |
| mask_i | input | 8 | Field mask |
| mem_byte_i | input | 8 | Memory byte for a load, old destination byte for a store |
| reg_val_i | input | 32 | Destination register value for a load, source register value for a store |
| result_o | output | 32 | Registered result |
| valid_o | output | 1 | Pulses one cycle after start |

## Verification
The assertions check the following on every cycle:
- the valid pulse timing;
- that the result holds between starts;
- that the upper bits pass through on a load and are cleared on a store;
- that a store leaves every unmasked bit of the old byte in place;
- the zero-mask results.

Only the bench scenarios can show that the field itself lands in the right place. This covers the lowest-set-bit shift for single-bit, contiguous and gapped masks, and the exact merged values, which the bench compares against worked byte values and a behavioural model.

// File: rtl/bfu_pkg.sv
package bfu_pkg;
  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } bfu_op_e;
endpackage

// File: rtl/bfu_lsb_index.sv
module bfu_lsb_index #(
  parameter int W     = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     mask_i,
  output logic [IDX_W-1:0] idx_o
);
  // Scan from the top so the lowest set bit wins; a zero mask gives index 0.
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/bfu_extract.sv
module bfu_extract #(
  parameter int W     = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     data_i,
  input  logic [W-1:0]     mask_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [W-1:0]     field_o
);
  assign field_o = (data_i & mask_i) >> idx_i;
endmodule

// File: rtl/bfu_insert.sv
module bfu_insert #(
  parameter int W     = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     src_i,
  input  logic [W-1:0]     old_i,
  input  logic [W-1:0]     mask_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [W-1:0]     merged_o
);
  logic [W-1:0] placed;
  assign placed   = src_i << idx_i;
  assign merged_o = (placed & mask_i) | (old_i & ~mask_i);
endmodule

// File: rtl/bfu_top.sv
module bfu_top
  import bfu_pkg::*;
#(
  parameter int FIELD_W = 8,
  parameter int REG_W   = 32,
  localparam int IDX_W  = $clog2(FIELD_W)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               op_i,
  input  logic [FIELD_W-1:0] mask_i,
  input  logic [FIELD_W-1:0] mem_byte_i,
  input  logic [REG_W-1:0]   reg_val_i,
  output logic [REG_W-1:0]   result_o,
  output logic               valid_o
);
  logic [IDX_W-1:0]   lsb_idx;
  logic [FIELD_W-1:0] ld_field;
  logic [FIELD_W-1:0] st_byte;
  logic [REG_W-1:0]   next_res;
  bfu_op_e            op;

  assign op = bfu_op_e'(op_i);

  bfu_lsb_index #(.W(FIELD_W)) u_idx (
    .mask_i (mask_i),
    .idx_o  (lsb_idx)
  );

  bfu_extract #(.W(FIELD_W)) u_ext (
    .data_i  (mem_byte_i),
    .mask_i  (mask_i),
    .idx_i   (lsb_idx),
    .field_o (ld_field)
  );

  bfu_insert #(.W(FIELD_W)) u_ins (
    .src_i    (reg_val_i[FIELD_W-1:0]),
    .old_i    (mem_byte_i),
    .mask_i   (mask_i),
    .idx_i    (lsb_idx),
    .merged_o (st_byte)
  );

  always_comb begin
    if (op == OP_LOAD) next_res = {reg_val_i[REG_W-1:FIELD_W], ld_field};
    else               next_res = {{(REG_W-FIELD_W){1'b0}}, st_byte};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= start_i;
      if (start_i) result_o <= next_res;
    end
  end
endmodule

// File: rtl/bfu_checker.sv
module bfu_checker #(
  parameter int FIELD_W = 8,
  parameter int REG_W   = 32
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               start_i,
  input logic               op_i,
  input logic [FIELD_W-1:0] mask_i,
  input logic [FIELD_W-1:0] mem_byte_i,
  input logic [REG_W-1:0]   reg_val_i,
  input logic [REG_W-1:0]   result_o,
  input logic               valid_o
);
  assert_valid_after_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> valid_o);

  assert_no_spurious_valid_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> !valid_o);

  assert_result_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i |=> $stable(result_o));

  assert_load_upper_pass_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !op_i) |=> result_o[REG_W-1:FIELD_W] == $past(reg_val_i[REG_W-1:FIELD_W]));

  assert_store_upper_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i) |=> result_o[REG_W-1:FIELD_W] == '0);

  assert_store_keeps_unmasked_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i) |=>
      (result_o[FIELD_W-1:0] & ~$past(mask_i)) == ($past(mem_byte_i) & ~$past(mask_i)));

  assert_zero_mask_load_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !op_i && mask_i == '0) |=> result_o[FIELD_W-1:0] == '0);

  assert_zero_mask_store_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && op_i && mask_i == '0) |=> result_o[FIELD_W-1:0] == $past(mem_byte_i));

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_idle_R1: assert (!valid_o && result_o == '0);
  end
endmodule

bind bfu_top bfu_checker #(.FIELD_W(FIELD_W), .REG_W(REG_W)) u_bfu_checker (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .op_i       (op_i),
  .mask_i     (mask_i),
  .mem_byte_i (mem_byte_i),
  .reg_val_i  (reg_val_i),
  .result_o   (result_o),
  .valid_o    (valid_o)
);

// File: tb/tb_bfu_top.sv
module tb_bfu_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        op = 1'b0;
  logic [7:0]  mask = '0;
  logic [7:0]  mem_b = '0;
  logic [31:0] reg_v = '0;
  logic [31:0] result;
  logic        valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  bfu_top dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .mask_i(mask),
    .mem_byte_i(mem_b), .reg_val_i(reg_v), .result_o(result), .valid_o(valid)
  );

  always #2 clk = ~clk;

  function automatic int low_idx(input logic [7:0] m);
    int r = 0;
    for (int i = 7; i >= 0; i--) if (m[i]) r = i;
    return r;
  endfunction

  function automatic logic [31:0] model(input logic o, input logic [7:0] m,
                                        input logic [7:0] b, input logic [31:0] r);
    int k = low_idx(m);
    logic [7:0] f;
    if (!o) begin
      f = 8'((b & m) >> k);
      return {r[31:8], f};
    end
    f = (8'(r[7:0] << k) & m) | (b & ~m);
    return {24'h0, f};
  endfunction

  // Behavioural reference, compared on every clock
  logic        m_valid;
  logic [31:0] m_res;
  logic [31:0] q_res[$];
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_res   <= '0;
    end else begin
      m_valid <= start;
      if (start) m_res <= model(op, mask, mem_b, reg_v);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (valid !== m_valid || result !== m_res) begin
        errors++;
        $display("FAIL R2/R8 per-cycle: valid=%0b result=%h expected valid=%0b result=%h",
                 valid, result, m_valid, m_res);
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input string tag, input logic o, input logic [7:0] m,
                     input logic [7:0] b, input logic [31:0] r, input logic [31:0] exp);
    @(negedge clk);
    start = 1'b1; op = o; mask = m; mem_b = b; reg_v = r;
    @(negedge clk);
    start = 1'b0;
    check(tag, {31'h0, valid}, 32'h1);
    check(tag, result, exp);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", {31'h0, valid}, 32'h0);
    check("R1 reset result", result, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", result, 32'h0);

    // R3/R4: loads of 0xA5 into 0xA5A5A5A5
    run("R3 load m01", 1'b0, 8'h01, 8'hA5, 32'hA5A5A5A5, 32'hA5A5A501);
    run("R3 load m02", 1'b0, 8'h02, 8'hA5, 32'hA5A5A5A5, 32'hA5A5A500);
    run("R3 load m07", 1'b0, 8'h07, 8'hA5, 32'hA5A5A5A5, 32'hA5A5A505);
    run("R3 load m20", 1'b0, 8'h20, 8'hA5, 32'hA5A5A5A5, 32'hA5A5A501);
    run("R4 load mF0", 1'b0, 8'hF0, 8'hA5, 32'hA5A5A5A5, 32'hA5A5A50A);
    run("R3 load m80", 1'b0, 8'h80, 8'hA5, 32'hA5A5A5A5, 32'hA5A5A501);
    run("R3 load mE0", 1'b0, 8'hE0, 8'hA5, 32'hA5A5A5A5, 32'hA5A5A505);
    run("R3 load m3C", 1'b0, 8'h3C, 8'hA5, 32'hA5A5A5A5, 32'hA5A5A509);
    run("R3 load mFE", 1'b0, 8'hFE, 8'hA5, 32'hA5A5A5A5, 32'hA5A5A552);
    run("R4 load upper", 1'b0, 8'hFF, 8'h3C, 32'h12345678, 32'h1234563C);
    run("R6 load zero mask", 1'b0, 8'h00, 8'hA5, 32'hA5A5A5A5, 32'hA5A5A500);

    // R5: stores of source 0xA5
    run("R5 store m01", 1'b1, 8'h01, 8'h00, 32'hA5A5A5A5, 32'h00000001);
    run("R5 store m02", 1'b1, 8'h02, 8'h00, 32'hA5A5A5A5, 32'h00000002);
    run("R5 store mF0", 1'b1, 8'hF0, 8'h00, 32'hA5A5A5A5, 32'h00000050);
    run("R5 store m80", 1'b1, 8'h80, 8'h00, 32'hA5A5A5A5, 32'h00000080);
    run("R5 store mE0", 1'b1, 8'hE0, 8'h00, 32'hA5A5A5A5, 32'h000000A0);
    run("R5 store m3C", 1'b1, 8'h3C, 8'h00, 32'hA5A5A5A5, 32'h00000014);
    run("R5 store mFE", 1'b1, 8'hFE, 8'h00, 32'hA5A5A5A5, 32'h0000004A);
    run("R5 store m38", 1'b1, 8'h38, 8'h00, 32'hA5A5A5A5, 32'h00000028);
    run("R5 store merge", 1'b1, 8'h3C, 8'hC3, 32'hA5A5A5A5, 32'h000000D7);
    run("R6 store zero mask", 1'b1, 8'h00, 8'h3C, 32'hA5A5A5A5, 32'h0000003C);

    // R7: gapped masks
    run("R7 load gapped", 1'b0, 8'h81, 8'hA5, 32'h00000000, 32'h00000081);
    run("R7 store gapped", 1'b1, 8'h81, 8'h00, 32'h00000003, 32'h00000001);

    // R8: idle cycles with moving inputs
    @(negedge clk);
    op = 1'b0; mask = 8'hFF; mem_b = 8'h5A; reg_v = 32'hDEADBEEF;
    repeat (3) @(negedge clk);
    check("R8 hold", result, 32'h00000001);
    check("R2 no valid when idle", {31'h0, valid}, 32'h0);

    // R2: back-to-back starts
    @(negedge clk);
    start = 1'b1; op = 1'b0; mask = 8'h0F; mem_b = 8'h96; reg_v = 32'h0;
    @(negedge clk);
    op = 1'b1; mask = 8'hF0; mem_b = 8'h0F; reg_v = 32'h3;
    check("R2 b2b first", result, 32'h00000006);
    @(negedge clk);
    start = 1'b0;
    check("R2 b2b second", result, 32'h0000003F);
    check("R2 b2b valid", {31'h0, valid}, 32'h1);
    @(negedge clk);
    check("R2 valid drop", {31'h0, valid}, 32'h0);

    finish_run();
  end
endmodule